// File: doc/BRIEF.md
# Single-Cycle Execute Datapath

This block is the execute half of a simple 32-bit processor. It takes an instruction word together with control bits that have already been decoded. In one clock cycle it reads two source registers and forms the second ALU operand. It computes the result and writes the value chosen for write-back into the destination register at the clock edge that ends the cycle.

The ALU operand mux and the write-back mux let the same ALU do two jobs. It produces register-register and register-immediate results, and it also produces the address for loads and stores. For arithmetic results the data memory is bypassed, and for loads the memory read data is written back instead. The data memory sits outside the block and is reached through a plain address, write-data, write-enable and read-data port. Reads from that memory are combinational.

Instruction fields sit at fixed positions. The first source register is instr[25:21], the second source register is instr[20:16], the register-register destination is instr[15:11] and the immediate is instr[15:0]. Bits 31:26 are not used by this block.

Top module: `sc_datapath`

## Requirements
- R1: After reset every register reads as zero.
- R2: Register 0 always reads as zero, and a write aimed at it has no effect.
- R3: With ctl_alu_imm low, operand B is the register selected by instr[20:16], and the result is written to the register selected by instr[15:11].
- R4: With ctl_alu_imm high, operand B is instr[15:0] sign-extended to 32 bits, and the destination is the register selected by instr[20:16].
- R5: ctl_alu_op selects the ALU function: 3'b000 AND, 3'b001 OR, 3'b010 add, 3'b110 subtract (A minus B), 3'b111 signed set-less-than (result 1 or 0). Every other code gives a result of zero.
- R6: alu_zero is high exactly when the ALU result is zero.
- R7: A load (ctl_alu_imm=1, ctl_wb_mem=1, op add) presents the sum of the first source register and the sign-extended immediate on mem_addr, and writes mem_rdata to the register selected by instr[20:16].
- R8: A store (ctl_mem_we=1, ctl_reg_we=0) drives mem_we high, drives the address from the first source register plus the sign-extended immediate, drives the value of the register selected by instr[20:16] on mem_wdata, and leaves every register unchanged.
- R9: A register write takes effect at the clock edge that ends the cycle. A read of that register in the same cycle sees the old value, and the new value is seen from the next cycle on.
- R10: With ctl_reg_we low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Instruction word carrying register fields and immediate |
| ctl_reg_we | input | 1 | Write the write-back value to the destination register |
| ctl_alu_imm | input | 1 | Operand B from the immediate and destination from instr[20:16] |
| ctl_wb_mem | input | 1 | Write back memory read data instead of the ALU result |
| ctl_mem_we | input | 1 | Store request |
| ctl_alu_op | input | 3 | ALU function code |
| mem_rdata | input | 32 | Data memory read data |
| mem_addr | output | 32 | ALU result, used as the memory address |
| mem_wdata | output | 32 | Store data taken from the second read port |
| mem_we | output | 1 | Memory write strobe |
| wb_data | output | 32 | Value on the register write-back bus |
| alu_zero | output | 1 | ALU result is zero |

## Verification
The assertions take it for granted that the control bits are consistent: a store never asserts the register write enable in the same cycle. They also expect the control inputs to be held at zero throughout reset, so that the write-landing check has a defined previous cycle. The bench drives every control combination from small helper tasks that build only legal loads, stores and arithmetic operations, and it changes inputs only on the falling edge. Register contents are brought out by issuing an add-immediate of zero with writes disabled and reading mem_addr, so no register changes during a read-back.

// File: rtl/dp_pkg.sv
package dp_pkg;
   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;
endpackage

// File: rtl/dp_sext.sv
module dp_sext #(
   parameter int IMM_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] ext
);
   localparam int PAD_W = DATA_W - IMM_W;

   if (PAD_W < 0) begin : g_bad_width
      $error("dp_sext: DATA_W must not be below IMM_W");
   end

   if (PAD_W == 0) begin : g_pass
      assign ext = imm;
   end else begin : g_pad
      assign ext = {{PAD_W{imm[IMM_W-1]}}, imm};
   end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [2:0]        op,
   output logic [DATA_W-1:0] res,
   output logic              zero
);
   if (DATA_W < 2) begin : g_bad_width
      $error("dp_alu: DATA_W must be at least 2");
   end

   alu_op_e op_e;
   assign op_e = alu_op_e'(op);

   always_comb begin
      case (op_e)
         ALU_AND: res = opa & opb;
         ALU_OR:  res = opa | opb;
         ALU_ADD: res = opa + opb;
         ALU_SUB: res = opa - opb;
         ALU_SLT: res = {{(DATA_W-1){1'b0}}, ($signed(opa) < $signed(opb))};
         default: res = '0;
      endcase
   end

   assign zero = (res == '0);

   AST_SUB_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'b110) |-> (zero == (opa == opb)));  // R6
   AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'b111) |-> ($countones(res) <= 1 && res[DATA_W-1:1] == '0));  // R5
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 32,
   parameter bit HARD_ZERO = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(REG_CNT)-1:0] ra_addr,
   output logic [DATA_W-1:0]          ra_data,
   input  logic [$clog2(REG_CNT)-1:0] rb_addr,
   output logic [DATA_W-1:0]          rb_data,
   input  logic                       wr_en,
   input  logic [$clog2(REG_CNT)-1:0] wr_addr,
   input  logic [DATA_W-1:0]          wr_data
);
   localparam int ADDR_W = $clog2(REG_CNT);

   if (REG_CNT < 2 || (1 << ADDR_W) != REG_CNT) begin : g_bad_depth
      $error("dp_regfile: REG_CNT must be a power of two, at least 2");
   end

   logic [REG_CNT*DATA_W-1:0] bank;

   for (genvar i = 0; i < REG_CNT; i++) begin : g_row
      if (i == 0 && HARD_ZERO) begin : g_zero
         assign bank[i*DATA_W +: DATA_W] = '0;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
               q <= wr_data;
         end
         assign bank[i*DATA_W +: DATA_W] = q;
      end
   end

   assign ra_data = bank[ra_addr*DATA_W +: DATA_W];
   assign rb_data = bank[rb_addr*DATA_W +: DATA_W];

   AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_addr == '0 && HARD_ZERO) |-> (ra_data == '0));  // R2
   AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_addr == '0 && HARD_ZERO) |-> (rb_data == '0));  // R2
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(wr_addr) != '0 && ra_addr == $past(wr_addr))
      |-> (ra_data == $past(wr_data)));  // R9
   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && ra_addr == $past(ra_addr)) |-> $stable(ra_data));  // R10
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
   import dp_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 32,
   parameter int IMM_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       instr,
   input  logic              ctl_reg_we,
   input  logic              ctl_alu_imm,
   input  logic              ctl_wb_mem,
   input  logic              ctl_mem_we,
   input  logic [2:0]        ctl_alu_op,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic [DATA_W-1:0] wb_data,
   output logic              alu_zero
);
   localparam int ADDR_W = $clog2(REG_CNT);
   localparam int FLD_W  = 5;
   localparam int RS_LSB = 21;
   localparam int RT_LSB = 16;
   localparam int RD_LSB = 11;

   if (ADDR_W > FLD_W) begin : g_bad_regs
      $error("sc_datapath: REG_CNT exceeds the register field range");
   end
   if (IMM_W > 16 || IMM_W > DATA_W) begin : g_bad_imm
      $error("sc_datapath: IMM_W must fit instr[15:0] and DATA_W");
   end

   logic [ADDR_W-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
   logic [DATA_W-1:0] rs_val, rt_val, imm_ext, opb, alu_res;
   logic [5:0]        unused_opcode;

   assign unused_opcode = instr[31:26];
   assign rs_idx  = instr[RS_LSB +: ADDR_W];
   assign rt_idx  = instr[RT_LSB +: ADDR_W];
   assign rd_idx  = instr[RD_LSB +: ADDR_W];
   assign dst_idx = ctl_alu_imm ? rt_idx : rd_idx;

   dp_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .HARD_ZERO(1'b1)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_addr (rs_idx),
      .ra_data (rs_val),
      .rb_addr (rt_idx),
      .rb_data (rt_val),
      .wr_en   (ctl_reg_we),
      .wr_addr (dst_idx),
      .wr_data (wb_data)
   );

   dp_sext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_sext (
      .imm (instr[IMM_W-1:0]),
      .ext (imm_ext)
   );

   assign opb = ctl_alu_imm ? imm_ext : rt_val;

   dp_alu #(.DATA_W(DATA_W)) u_alu (
      .clk   (clk),
      .rst_n (rst_n),
      .opa   (rs_val),
      .opb   (opb),
      .op    (ctl_alu_op),
      .res   (alu_res),
      .zero  (alu_zero)
   );

   assign mem_addr  = alu_res;
   assign mem_wdata = rt_val;
   assign mem_we    = ctl_mem_we;
   assign wb_data   = ctl_wb_mem ? mem_rdata : alu_res;

   AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_mem_we |-> !ctl_reg_we);  // R8
   AST_LOAD_WB: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wb_mem |-> (wb_data == mem_rdata));  // R7
   AST_BYPASS_WB: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wb_mem |-> (wb_data == mem_addr));  // R3
   AST_IMM_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_alu_imm && ctl_alu_op == 3'b010)
      |-> ($signed(mem_addr) == $signed(rs_val) + $signed(instr[IMM_W-1:0])));  // R4
endmodule

// File: tb/tb_sc_datapath.sv
module tb_sc_datapath;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic        ctl_reg_we = 1'b0, ctl_alu_imm = 1'b0, ctl_wb_mem = 1'b0, ctl_mem_we = 1'b0;
   logic [2:0]  ctl_alu_op = 3'b000;
   logic [31:0] mem_rdata, mem_addr, mem_wdata, wb_data;
   logic        mem_we, alu_zero;

   int checks = 0;
   int errors = 0;

   logic [31:0] dmem [16];

   always #5 clk = ~clk;

   assign mem_rdata = dmem[mem_addr[5:2]];
   always @(posedge clk) if (mem_we) dmem[mem_addr[5:2]] <= mem_wdata;

   sc_datapath dut (
      .clk(clk), .rst_n(rst_n), .instr(instr),
      .ctl_reg_we(ctl_reg_we), .ctl_alu_imm(ctl_alu_imm), .ctl_wb_mem(ctl_wb_mem),
      .ctl_mem_we(ctl_mem_we), .ctl_alu_op(ctl_alu_op), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .wb_data(wb_data), .alu_zero(alu_zero)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rr(input int rs, input int rt, input int rd);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], 11'd0};
   endfunction

   function automatic logic [31:0] ri(input int rs, input int rt, input logic [15:0] imm);
      return {6'd0, rs[4:0], rt[4:0], imm};
   endfunction

   // drive one operation at the falling edge, settle, leave it for the next rising edge
   task automatic issue(input logic [31:0] iw, input logic we, input logic imm,
                        input logic wbm, input logic mw, input logic [2:0] op);
      @(negedge clk);
      instr = iw; ctl_reg_we = we; ctl_alu_imm = imm;
      ctl_wb_mem = wbm; ctl_mem_we = mw; ctl_alu_op = op;
      #1;
   endtask

   task automatic read_reg(input int r, output logic [31:0] v);
      issue(ri(r, 0, 16'h0000), 1'b0, 1'b1, 1'b0, 1'b0, 3'b010);
      v = mem_addr;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      read_reg(1, v);  check("R1 r1 after reset", v, 32'h0);
      read_reg(31, v); check("R1 r31 after reset", v, 32'h0);
   endtask

   task automatic t_immediate;
      logic [31:0] v;
      issue(ri(0, 1, 16'd5), 1'b1, 1'b1, 1'b0, 1'b0, 3'b010);
      issue(ri(0, 2, 16'hFFFD), 1'b1, 1'b1, 1'b0, 1'b0, 3'b010);
      read_reg(1, v); check("R4 addi positive into rt", v, 32'd5);
      read_reg(2, v); check("R4 addi sign-extended", v, 32'hFFFF_FFFD);
   endtask

   task automatic t_reg_reg;
      logic [31:0] v;
      issue(rr(1, 2, 3), 1'b1, 1'b0, 1'b0, 1'b0, 3'b010);
      issue(rr(1, 2, 4), 1'b1, 1'b0, 1'b0, 1'b0, 3'b110);
      issue(rr(1, 2, 5), 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
      issue(rr(1, 2, 6), 1'b1, 1'b0, 1'b0, 1'b0, 3'b001);
      issue(rr(2, 1, 7), 1'b1, 1'b0, 1'b0, 1'b0, 3'b111);
      issue(rr(1, 2, 8), 1'b1, 1'b0, 1'b0, 1'b0, 3'b111);
      issue(ri(0, 9, 16'd7), 1'b1, 1'b1, 1'b0, 1'b0, 3'b010);
      issue(rr(1, 2, 9), 1'b1, 1'b0, 1'b0, 1'b0, 3'b011);
      read_reg(3, v); check("R3 add rd", v, 32'd2);
      read_reg(4, v); check("R5 sub", v, 32'd8);
      read_reg(5, v); check("R5 and", v, 32'd5);
      read_reg(6, v); check("R5 or", v, 32'hFFFF_FFFD);
      read_reg(7, v); check("R5 slt true signed", v, 32'd1);
      read_reg(8, v); check("R5 slt false", v, 32'd0);
      read_reg(9, v); check("R5 undefined code gives zero", v, 32'd0);
   endtask

   task automatic t_zero_flag;
      issue(rr(1, 1, 0), 1'b0, 1'b0, 1'b0, 1'b0, 3'b110);
      check("R6 zero on equal sub", {31'd0, alu_zero}, 32'd1);
      issue(rr(1, 2, 0), 1'b0, 1'b0, 1'b0, 1'b0, 3'b110);
      check("R6 zero low on nonzero", {31'd0, alu_zero}, 32'd0);
   endtask

   task automatic t_reg_zero;
      logic [31:0] v;
      issue(ri(0, 0, 16'd9), 1'b1, 1'b1, 1'b0, 1'b0, 3'b010);
      read_reg(0, v); check("R2 r0 stays zero", v, 32'd0);
   endtask

   task automatic t_store;
      logic [31:0] v;
      issue(ri(0, 1, 16'd8), 1'b0, 1'b1, 1'b0, 1'b1, 3'b010);
      check("R8 store address", mem_addr, 32'd8);
      check("R8 store data", mem_wdata, 32'd5);
      check("R8 store strobe", {31'd0, mem_we}, 32'd1);
      issue(ri(1, 2, 16'hFFFF), 1'b0, 1'b1, 1'b0, 1'b1, 3'b010);
      check("R8 store negative offset", mem_addr, 32'd4);
      read_reg(1, v); check("R8 store leaves rt", v, 32'd5);
      read_reg(2, v); check("R8 store leaves r2", v, 32'hFFFF_FFFD);
   endtask

   task automatic t_load;
      logic [31:0] v;
      issue(ri(1, 10, 16'd3), 1'b1, 1'b1, 1'b1, 1'b0, 3'b010);
      check("R7 load address", mem_addr, 32'd8);
      check("R7 load write-back bus", wb_data, 32'd5);
      issue(ri(0, 12, 16'd4), 1'b1, 1'b1, 1'b1, 1'b0, 3'b010);
      read_reg(10, v); check("R7 load into rt", v, 32'd5);
      read_reg(12, v); check("R7 load second word", v, 32'hFFFF_FFFD);
   endtask

   task automatic t_write_timing;
      logic [31:0] v;
      issue(ri(11, 11, 16'd1), 1'b1, 1'b1, 1'b0, 1'b0, 3'b010);
      check("R9 same-cycle read sees old", mem_addr, 32'd1);
      issue(ri(11, 11, 16'd1), 1'b1, 1'b1, 1'b0, 1'b0, 3'b010);
      check("R9 next cycle sees new", mem_addr, 32'd2);
      read_reg(11, v); check("R9 final value", v, 32'd2);
   endtask

   task automatic t_we_low;
      logic [31:0] v;
      issue(rr(2, 2, 3), 1'b0, 1'b0, 1'b0, 1'b0, 3'b010);
      issue(ri(0, 1, 16'd77), 1'b0, 1'b1, 1'b0, 1'b0, 3'b010);
      read_reg(3, v); check("R10 rd unchanged", v, 32'd2);
      read_reg(1, v); check("R10 rt unchanged", v, 32'd5);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) dmem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_immediate();
      t_reg_reg();
      t_zero_flag();
      t_reg_zero();
      t_store();
      t_load();
      t_write_timing();
      t_we_low();
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule